// File: doc/BRIEF.md
# Time-of-Day Ripple Counter Chain

This block keeps time of day for a simple digital clock. Five counting stages sit in a fixed chain: units of seconds, tens of seconds, units of minutes, tens of minutes and hours. A one-pulse-per-second level, `pps_i`, drives the first stage. Each later stage is driven by the most significant bit of the stage before it. A stage counts one step each time its driving level goes from high to low, so the chain behaves like a ripple counter. Every stage change is timed by the single system clock `clk_i`.

Each stage watches its driving level with a two-state machine. In `LVL_LOW` it waits for the level to go high and takes transition *arm* to `LVL_HIGH`, which produces no count. In `LVL_HIGH` it waits for the level to go low and takes transition *fire* back to `LVL_LOW`. *Fire* produces a one-cycle step, and on that clock edge the stage counter either increments or wraps to 0. Because each detector samples a registered count, a carry reaches each following stage one clock later than the stage before it. A full rollover therefore settles over five clocks.

Each stage presents two outputs: its binary count, and a one-of-n decode of that count for driving a display.

Top module: `tod_chain`

## Requirements
- R1: The stages count 0..9 (seconds units), 0..5 (seconds tens), 0..9 (minutes units), 0..5 (minutes tens) and 0..11 (hours). Each stage wraps to 0 on the step after its top value.
- R2: When `pps_i` is high at one rising `clk_i` edge and low at the next, the seconds-units count advances by one on that second edge.
- R3: A rising `pps_i`, or a steady high `pps_i`, never changes any count.
- R4: Each later stage steps on a high-to-low change of the previous stage's count bit 3 (bit 2 for the 3-bit tens stages). This happens only when the previous stage wraps. The step lands one clock after the previous stage changed.
- R5: `rst_i` is synchronous and active high. It clears every count to 0 and sets every one-hot output to bit 0.
- R6: Bit k of a stage's one-hot output is set exactly when that stage's count equals k, so exactly one bit is set after reset.
- R7: Without a step, a stage holds its count.
- R8: A step at 11:59:59 returns every stage to 0 once the ripple has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pps_i | input | 1 | One-pulse-per-second level; its falling edge steps seconds |
| sec_ones_cnt_o | output | 4 | Seconds units count |
| sec_ones_hot_o | output | 10 | One-hot decode of seconds units |
| sec_tens_cnt_o | output | 3 | Seconds tens count |
| sec_tens_hot_o | output | 6 | One-hot decode of seconds tens |
| min_ones_cnt_o | output | 4 | Minutes units count |
| min_ones_hot_o | output | 10 | One-hot decode of minutes units |
| min_tens_cnt_o | output | 3 | Minutes tens count |
| min_tens_hot_o | output | 6 | One-hot decode of minutes tens |
| hour_cnt_o | output | 4 | Hours count |
| hour_hot_o | output | 12 | One-hot decode of hours |

## Verification
The assertions take for granted that `pps_i` is a clean level that stays constant for at least one full clock cycle between changes. They also take for granted that reset is held for at least two clocks at start-up, so that each edge check that looks one cycle back sees settled counts. The stimulus changes `pps_i` only on falling clock edges, holds every pulse high and low for at least one cycle each, and drives reset for several cycles. Checks that span a carry wait six clocks so the whole chain has settled before sampling.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int SEC_ONES_MOD_DEF = 10;
    localparam int SEC_TENS_MOD_DEF = 6;
    localparam int MIN_ONES_MOD_DEF = 10;
    localparam int MIN_TENS_MOD_DEF = 6;
    localparam int HOUR_MOD_DEF     = 12;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/tod_fall_det.sv
module tod_fall_det
    import tod_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic fall_o
);

    lvl_state_e state_q;
    lvl_state_e state_d;

    // next state: arm on high, fire on low
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= LVL_LOW;
        else       state_q <= state_d;
    end

    // outputs
    always_comb begin
        fall_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  fall_o = 1'b0;
            LVL_HIGH: fall_o = !lvl_i;
            default:  fall_o = 1'b0;
        endcase
    end

    AST_NO_STEP_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        lvl_i |-> !fall_o); // R3

    AST_FALL_GIVES_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $fell(lvl_i)) |-> fall_o); // R2

endmodule

// File: rtl/tod_onehot.sv
module tod_onehot #(
    parameter int N = 10
) (
    input  logic [$clog2(N)-1:0] idx_i,
    output logic [N-1:0]         hot_o
);

    localparam int W = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign hot_o[g] = (idx_i == W'(g));
    end

endmodule

// File: rtl/tod_stage.sv
module tod_stage #(
    parameter int MOD = 10
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   drv_i,
    output logic [$clog2(MOD)-1:0] cnt_o,
    output logic [MOD-1:0]         hot_o
);

    localparam int          W   = $clog2(MOD);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic         step;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    tod_fall_det u_fall (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (drv_i),
        .fall_o (step)
    );

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            if (cnt_q == TOP) cnt_d = '0;
            else              cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    tod_onehot #(.N(MOD)) u_dec (
        .idx_i (cnt_q),
        .hot_o (hot_o)
    );

    assign cnt_o = cnt_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= TOP); // R1

    AST_STEP_ADVANCES: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + W'(1))); // R1

    AST_STEP_WRAPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && cnt_q == TOP) |=> (cnt_q == '0)); // R1

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !step |=> $stable(cnt_q)); // R7

    AST_ONE_HOT_DISPLAY: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(hot_o)); // R6

    AST_MSB_FALLS_ON_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $fell(cnt_q[W-1])) |-> ($past(cnt_q) == TOP)); // R4

endmodule

// File: rtl/tod_chain.sv
module tod_chain
    import tod_pkg::*;
#(
    parameter int SEC_ONES_MOD = SEC_ONES_MOD_DEF,
    parameter int SEC_TENS_MOD = SEC_TENS_MOD_DEF,
    parameter int MIN_ONES_MOD = MIN_ONES_MOD_DEF,
    parameter int MIN_TENS_MOD = MIN_TENS_MOD_DEF,
    parameter int HOUR_MOD     = HOUR_MOD_DEF
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            pps_i,
    output logic [$clog2(SEC_ONES_MOD)-1:0] sec_ones_cnt_o,
    output logic [SEC_ONES_MOD-1:0]         sec_ones_hot_o,
    output logic [$clog2(SEC_TENS_MOD)-1:0] sec_tens_cnt_o,
    output logic [SEC_TENS_MOD-1:0]         sec_tens_hot_o,
    output logic [$clog2(MIN_ONES_MOD)-1:0] min_ones_cnt_o,
    output logic [MIN_ONES_MOD-1:0]         min_ones_hot_o,
    output logic [$clog2(MIN_TENS_MOD)-1:0] min_tens_cnt_o,
    output logic [MIN_TENS_MOD-1:0]         min_tens_hot_o,
    output logic [$clog2(HOUR_MOD)-1:0]     hour_cnt_o,
    output logic [HOUR_MOD-1:0]             hour_hot_o
);

    localparam int SO_W = $clog2(SEC_ONES_MOD);
    localparam int ST_W = $clog2(SEC_TENS_MOD);
    localparam int MO_W = $clog2(MIN_ONES_MOD);
    localparam int MT_W = $clog2(MIN_TENS_MOD);

    tod_stage #(.MOD(SEC_ONES_MOD)) u_sec_ones (
        .clk_i (clk_i), .rst_i (rst_i), .drv_i (pps_i),
        .cnt_o (sec_ones_cnt_o), .hot_o (sec_ones_hot_o)
    );

    tod_stage #(.MOD(SEC_TENS_MOD)) u_sec_tens (
        .clk_i (clk_i), .rst_i (rst_i), .drv_i (sec_ones_cnt_o[SO_W-1]),
        .cnt_o (sec_tens_cnt_o), .hot_o (sec_tens_hot_o)
    );

    tod_stage #(.MOD(MIN_ONES_MOD)) u_min_ones (
        .clk_i (clk_i), .rst_i (rst_i), .drv_i (sec_tens_cnt_o[ST_W-1]),
        .cnt_o (min_ones_cnt_o), .hot_o (min_ones_hot_o)
    );

    tod_stage #(.MOD(MIN_TENS_MOD)) u_min_tens (
        .clk_i (clk_i), .rst_i (rst_i), .drv_i (min_ones_cnt_o[MO_W-1]),
        .cnt_o (min_tens_cnt_o), .hot_o (min_tens_hot_o)
    );

    tod_stage #(.MOD(HOUR_MOD)) u_hour (
        .clk_i (clk_i), .rst_i (rst_i), .drv_i (min_tens_cnt_o[MT_W-1]),
        .cnt_o (hour_cnt_o), .hot_o (hour_hot_o)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (sec_ones_cnt_o == '0 && sec_tens_cnt_o == '0 &&
                   min_ones_cnt_o == '0 && min_tens_cnt_o == '0 &&
                   hour_cnt_o == '0 && hour_hot_o[0])); // R5

    AST_TENS_ONLY_AFTER_UNITS_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && sec_tens_cnt_o != $past(sec_tens_cnt_o))
            |-> ($past(sec_ones_cnt_o) == '0)); // R4

endmodule

// File: tb/sim_tod_chain.sv
module sim_tod_chain;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps = 1'b0;
    logic [3:0]  so_cnt;
    logic [9:0]  so_hot;
    logic [2:0]  st_cnt;
    logic [5:0]  st_hot;
    logic [3:0]  mo_cnt;
    logic [9:0]  mo_hot;
    logic [2:0]  mt_cnt;
    logic [5:0]  mt_hot;
    logic [3:0]  hr_cnt;
    logic [11:0] hr_hot;

    int tests  = 0;
    int fails  = 0;
    int secs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tod_chain u0 (
        .clk_i (clk), .rst_i (rst), .pps_i (pps),
        .sec_ones_cnt_o (so_cnt), .sec_ones_hot_o (so_hot),
        .sec_tens_cnt_o (st_cnt), .sec_tens_hot_o (st_hot),
        .min_ones_cnt_o (mo_cnt), .min_ones_hot_o (mo_hot),
        .min_tens_cnt_o (mt_cnt), .min_tens_hot_o (mt_hot),
        .hour_cnt_o (hr_cnt), .hour_hot_o (hr_hot)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_time(input string req);
        int u;
        u = secs % 43200;
        check(req, "sec_ones", int'(so_cnt), u % 10);
        check(req, "sec_tens", int'(st_cnt), (u / 10) % 6);
        check(req, "min_ones", int'(mo_cnt), (u / 60) % 10);
        check(req, "min_tens", int'(mt_cnt), (u / 600) % 6);
        check(req, "hours",    int'(hr_cnt), (u / 3600) % 12);
        check("R6", "sec_ones_hot", int'(so_hot), 1 << (u % 10));
        check("R6", "sec_tens_hot", int'(st_hot), 1 << ((u / 10) % 6));
        check("R6", "min_ones_hot", int'(mo_hot), 1 << ((u / 60) % 10));
        check("R6", "min_tens_hot", int'(mt_hot), 1 << ((u / 600) % 6));
        check("R6", "hours_hot",    int'(hr_hot), 1 << ((u / 3600) % 12));
    endtask

    task automatic pulse();
        pps = 1'b1;
        @(negedge clk);
        pps = 1'b0;
        @(negedge clk);
        secs++;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic run_to(input int target);
        while (secs < target) pulse();
        settle();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk); pps = ~pps;
        end
        pps = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        secs = 0;
        @(negedge clk);
        check_time("R5");
    endtask

    task automatic t_rise_ignored();
        pps = 1'b1;
        repeat (5) @(negedge clk);
        check("R3", "sec_ones after rise and hold", int'(so_cnt), 0);
        pps = 1'b0;
        @(negedge clk);
        secs = 1;
        check("R2", "sec_ones after fall", int'(so_cnt), 1);
        repeat (8) @(negedge clk);
        check("R7", "sec_ones held low", int'(so_cnt), 1);
        check_time("R7");
    endtask

    task automatic t_carry_latency();
        run_to(9);
        check_time("R1");
        pps = 1'b1;
        @(negedge clk);
        pps = 1'b0;
        @(negedge clk);
        check("R2", "sec_ones wraps", int'(so_cnt), 0);
        check("R4", "sec_tens not yet stepped", int'(st_cnt), 0);
        @(negedge clk);
        check("R4", "sec_tens stepped one clock later", int'(st_cnt), 1);
        secs = 10;
        settle();
        check_time("R1");
    endtask

    task automatic t_hour_carry();
        run_to(3599);
        check_time("R1");
        pulse();
        settle();
        check_time("R4");
    endtask

    task automatic t_mid_reset();
        run_to(3607);
        pps = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        secs = 0;
        check_time("R5");
        pps = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_time("R5");
    endtask

    task automatic t_day_wrap();
        run_to(43199);
        check_time("R1");
        pulse();
        settle();
        check("R8", "hours after 11:59:59", int'(hr_cnt), 0);
        check("R8", "sec_ones after 11:59:59", int'(so_cnt), 0);
        check_time("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rise_ignored();
        t_carry_latency();
        t_hour_carry();
        t_mid_reset();
        t_day_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule